// File: doc/BRIEF.md
# Asynchronous Parallel Memory Bus Sequencer

This block connects a simple internal request port to an external asynchronous parallel memory: static RAM, ferroelectric RAM, pseudo-static RAM or NOR flash. A request carries an address, write data, a read/write flag and byte enables. When the block accepts a request, it runs the external pins through a fixed order of phases. The byte lanes are enabled first. Then the address is set up, the address is held (multiplexed buses only), the strobe is active for data setup, data is held, and the bus is turned around. Each phase lasts a programmed number of internal clock cycles.

Reads and writes each have their own set of five timing values. The lane lead time is shared by both. On a multiplexed bus, the address is driven on the data lines and marked by an address-valid strobe. An external wait input can stretch the strobe phase. Its polarity is selectable, and it is ignored unless enabled. Reads return the captured data together with a one-cycle done pulse. Writes pulse done at the same point of the sequence.

The request side is a plain valid/ready pair. The block accepts one request when idle and does not accept another until the bus turnaround has finished.

Top module: `xmem_async_seq`

## Requirements
- R1: After reset, chip select, output enable, write enable and address-valid are high, both byte-lane enables are high, the data bus is not driven, `req_ready` is 1 and `rsp_done` is 0.
- R2: For a read, the enabled byte lanes go low `lead` cycles before chip select. Chip select is then low for address setup + address hold (multiplexed only) + data setup + data hold cycles. Output enable is low for the data setup cycles only.
- R3: A write takes all of its timing from `cfg_wr_tim`. Write enable is low for the write data setup cycles. The write data is driven on the bus during data setup and data hold.
- R4: Every timing value is a cycle count, and a zero skips its phase. The one exception is data setup: a value of zero still gives one strobe cycle.
- R5: Multiplexing takes effect only when `cfg_mux` is 1 and `cfg_kind` is 1 (PSRAM) or 2 (NOR). In that case the low 16 address bits are driven on the data bus for address setup + address hold cycles, and address-valid is low during address setup. With `cfg_kind` 0 (SRAM), `cfg_mux` has no effect and the address hold phase is skipped.
- R6: With `cfg_wait_en` set, each cycle of data setup in which the wait input is active adds one strobe cycle. With `cfg_wait_en` clear, the wait input has no effect on any timing.
- R7: The wait input is active when it equals `cfg_wait_high`. With 0 it is active low, and with 1 it is active high.
- R8: Read data is captured in the last cycle of data setup. `rsp_done` is high for exactly one cycle, the cycle after the last strobe cycle, and `rsp_rdata` is valid then.
- R9: With `cfg_wide` 0 (8-bit bus), only lane 0 is used. `mem_bl_n[1]` stays high, bits 15:8 of the write data bus are 0, and bits 15:8 of the read data are returned as 0.
- R10: After chip select rises and data hold ends, `req_ready` stays low for the `turn` cycles of the set just used.
- R11: `req_ready` is high only when the bus is idle. A request presented while `req_ready` is low is not accepted and starts no transaction.

Timing vectors hold five 4-bit fields, from the least significant upward: address setup, address hold, data setup, data hold, turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit i for lane i |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done of a read |
| cfg_rd_tim | input | 20 | Read timing set |
| cfg_wr_tim | input | 20 | Write timing set |
| cfg_lane_lead | input | 4 | Byte-lane lead cycles before chip select |
| cfg_kind | input | 2 | Memory kind: 0 SRAM/FRAM, 1 PSRAM, 2 NOR |
| cfg_mux | input | 1 | Request multiplexed address/data |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_wait_en | input | 1 | Honour the wait input |
| cfg_wait_high | input | 1 | Wait active level |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable (read strobe), active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid for multiplexed bus, active low |
| mem_bl_n | output | 2 | Byte-lane enables, active low |
| mem_addr | output | ADDR_W | Address lines |
| mem_dq_out | output | 16 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_in | input | 16 | Data bus input value |
| mem_wait | input | 1 | Wait from the memory |

## Verification
The bench measures every phase as a count of pin cycles and compares it with the programmed values. A phase that is off by one, a zero that is not skipped, or a data setup that is skipped at zero all show up as wrong chip-select or strobe lengths. Wait is driven at both polarities, and also while disabled. A design that ignores the polarity, or honours a disabled wait, produces a strobe with the wrong length. Multiplexing is requested on a static RAM, where a design that ignores the kind would produce address-valid pulses. The read bus returns a marker value outside the strobe, so capturing data one cycle late returns that marker. Extra requests are presented while the block is busy, and a design that accepted them would complete one transaction too many.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int DQ_W  = 16;
    localparam int LANES = DQ_W / 8;
    localparam int TIM_W = 4;
    localparam int NSET  = 5;
    localparam int SET_W = NSET * TIM_W;
    localparam int NPH   = 7;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LANE = 3'd1,
        PH_ASET = 3'd2,
        PH_AHLD = 3'd3,
        PH_DSET = 3'd4,
        PH_DHLD = 3'd5,
        PH_TURN = 3'd6
    } phase_e;

    typedef enum logic [1:0] {
        KIND_SRAM  = 2'd0,
        KIND_PSRAM = 2'd1,
        KIND_NOR   = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef logic [TIM_W-1:0] tim_t;

    // first member is the most significant field
    typedef struct packed {
        tim_t turn;
        tim_t dhld;
        tim_t dset;
        tim_t ahld;
        tim_t aset;
    } tim_set_t;

    typedef struct packed {
        tim_set_t             tim;
        tim_t                 lead;
        logic                 mux;
        logic                 wide;
        logic                 write;
        logic [LANES-1:0]     be;
    } txn_cfg_t;

    function automatic logic mux_allowed(kind_e k);
        return (k == KIND_PSRAM) || (k == KIND_NOR);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(logic wide);
        logic [LANES-1:0] m;
        m = wide ? {LANES{1'b1}} : {{(LANES-1){1'b0}}, 1'b1};
        return m;
    endfunction

    function automatic logic [DQ_W-1:0] byte_mask(logic [LANES-1:0] l);
        logic [DQ_W-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{l[i]}};
        return m;
    endfunction

    // first phase after cur whose length is non-zero, idle when none left
    function automatic phase_e next_phase(phase_e cur, logic [NPH-1:0] live);
        phase_e r;
        r = PH_IDLE;
        for (int i = NPH - 1; i >= 1; i--) begin
            if (i > int'(cur) && live[i]) r = phase_e'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/xmem_phase_len.sv
module xmem_phase_len
    import xmem_pkg::*;
(
    input  txn_cfg_t                     cfg,
    output logic [NPH-1:0][TIM_W-1:0]    len,
    output logic [NPH-1:0]               live
);

    always_comb begin
        len          = '0;
        len[PH_LANE] = cfg.lead;
        len[PH_ASET] = cfg.tim.aset;
        len[PH_AHLD] = cfg.mux ? cfg.tim.ahld : '0;
        len[PH_DSET] = (cfg.tim.dset == '0) ? TIM_W'(1) : cfg.tim.dset;
        len[PH_DHLD] = cfg.tim.dhld;
        len[PH_TURN] = cfg.tim.turn;
    end

    for (genvar g = 0; g < NPH; g++) begin : g_live
        assign live[g] = (len[g] != '0);
    end

endmodule

// File: rtl/xmem_phase_ctrl.sv
module xmem_phase_ctrl
    import xmem_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         accept,
    input  logic                         wait_act,
    input  logic [NPH-1:0][TIM_W-1:0]    len,
    input  logic [NPH-1:0]               live,
    output phase_e                       phase,
    output logic                         dset_end
);

    tim_t   cnt;
    phase_e nxt;
    phase_e first;
    logic   stall;
    logic   ph_end;

    always_comb begin
        stall    = (phase == PH_DSET) && wait_act;
        ph_end   = (phase != PH_IDLE) && (cnt == TIM_W'(1)) && !stall;
        nxt      = next_phase(phase, live);
        first    = next_phase(PH_IDLE, live);
        dset_end = ph_end && (phase == PH_DSET);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (phase == PH_IDLE) begin
            if (accept) begin
                phase <= first;
                cnt   <= len[first];
            end
        end else if (ph_end) begin
            phase <= nxt;
            cnt   <= len[nxt];
        end else if (!stall) begin
            cnt <= cnt - TIM_W'(1);
        end
    end

endmodule

// File: rtl/xmem_pin_drv.sv
module xmem_pin_drv
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  phase_e              phase,
    input  txn_cfg_t            cfg,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DQ_W-1:0]     wdata,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic                mem_adv_n,
    output logic [LANES-1:0]    mem_bl_n,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DQ_W-1:0]     mem_dq_out,
    output logic                mem_dq_oe
);

    logic in_txn;
    logic ce_on;
    logic addr_on_dq;
    logic data_on_dq;
    logic [DQ_W-1:0] addr_lo;

    always_comb begin
        in_txn     = phase inside {PH_LANE, PH_ASET, PH_AHLD, PH_DSET, PH_DHLD};
        ce_on      = phase inside {PH_ASET, PH_AHLD, PH_DSET, PH_DHLD};
        addr_on_dq = cfg.mux && (phase inside {PH_ASET, PH_AHLD});
        data_on_dq = cfg.write && (phase inside {PH_DSET, PH_DHLD});
        addr_lo    = DQ_W'(addr);

        mem_ce_n   = !ce_on;
        mem_oe_n   = !((phase == PH_DSET) && !cfg.write);
        mem_we_n   = !((phase == PH_DSET) && cfg.write);
        mem_adv_n  = !(cfg.mux && (phase == PH_ASET));
        mem_bl_n   = in_txn ? ~(cfg.be & lane_mask(cfg.wide)) : {LANES{1'b1}};
        mem_addr   = in_txn ? addr : '0;
        mem_dq_oe  = addr_on_dq || data_on_dq;
        if (addr_on_dq)
            mem_dq_out = addr_lo;
        else if (data_on_dq)
            mem_dq_out = wdata & byte_mask(lane_mask(cfg.wide));
        else
            mem_dq_out = '0;
    end

endmodule

// File: rtl/xmem_async_seq.sv
module xmem_async_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [15:0]          req_wdata,
    input  logic [1:0]           req_be,
    output logic                 rsp_done,
    output logic [15:0]          rsp_rdata,
    input  logic [19:0]          cfg_rd_tim,
    input  logic [19:0]          cfg_wr_tim,
    input  logic [3:0]           cfg_lane_lead,
    input  logic [1:0]           cfg_kind,
    input  logic                 cfg_mux,
    input  logic                 cfg_wide,
    input  logic                 cfg_wait_en,
    input  logic                 cfg_wait_high,
    output logic                 mem_ce_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic                 mem_adv_n,
    output logic [1:0]           mem_bl_n,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [15:0]          mem_dq_out,
    output logic                 mem_dq_oe,
    input  logic [15:0]          mem_dq_in,
    input  logic                 mem_wait
);

    txn_cfg_t                    in_cfg;
    txn_cfg_t                    held_cfg;
    txn_cfg_t                    eff_cfg;
    logic [ADDR_W-1:0]           held_addr;
    logic [DQ_W-1:0]             held_wdata;
    logic [NPH-1:0][TIM_W-1:0]   len;
    logic [NPH-1:0]              live;
    phase_e                      phase;
    logic                        dset_end;
    logic                        accept;
    logic                        wait_act;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign wait_act  = cfg_wait_en && (mem_wait == cfg_wait_high);

    always_comb begin
        in_cfg.tim   = req_write ? tim_set_t'(cfg_wr_tim[SET_W-1:0])
                                 : tim_set_t'(cfg_rd_tim[SET_W-1:0]);
        in_cfg.lead  = cfg_lane_lead[TIM_W-1:0];
        in_cfg.mux   = cfg_mux && mux_allowed(kind_e'(cfg_kind));
        in_cfg.wide  = cfg_wide;
        in_cfg.write = req_write;
        in_cfg.be    = req_be[LANES-1:0];
        eff_cfg      = accept ? in_cfg : held_cfg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_cfg   <= '0;
            held_addr  <= '0;
            held_wdata <= '0;
        end else if (accept) begin
            held_cfg   <= in_cfg;
            held_addr  <= req_addr;
            held_wdata <= req_wdata;
        end
    end

    xmem_phase_len u_len (
        .cfg  (eff_cfg),
        .len  (len),
        .live (live)
    );

    xmem_phase_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .wait_act (wait_act),
        .len      (len),
        .live     (live),
        .phase    (phase),
        .dset_end (dset_end)
    );

    xmem_pin_drv #(.ADDR_W(ADDR_W)) u_pins (
        .phase      (phase),
        .cfg        (held_cfg),
        .addr       (held_addr),
        .wdata      (held_wdata),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_adv_n  (mem_adv_n),
        .mem_bl_n   (mem_bl_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= dset_end;
            if (dset_end && !held_cfg.write)
                rsp_rdata <= mem_dq_in & byte_mask(lane_mask(held_cfg.wide));
        end
    end

endmodule

// File: rtl/xmem_async_seq_chk.sv
module xmem_async_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       rsp_done,
    input logic [1:0] cfg_kind,
    input logic       cfg_wide,
    input logic       mem_ce_n,
    input logic       mem_oe_n,
    input logic       mem_we_n,
    input logic       mem_adv_n,
    input logic [1:0] mem_bl_n,
    input logic       mem_dq_oe
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n)); // R2

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !mem_ce_n); // R2

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe); // R3

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe); // R2

    AST_ADV_ONLY_MUXABLE: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> (mem_dq_oe && (cfg_kind == 2'd1 || cfg_kind == 2'd2))); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R8

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(!mem_oe_n || !mem_we_n)); // R8

    AST_NARROW_LANE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wide && !mem_ce_n) |-> mem_bl_n[1]); // R9

    AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && mem_bl_n == 2'b11)); // R11

endmodule

bind xmem_async_seq xmem_async_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .cfg_kind  (cfg_kind),
    .cfg_wide  (cfg_wide),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_adv_n (mem_adv_n),
    .mem_bl_n  (mem_bl_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/xmem_async_seq_bench.sv
`timescale 1ns/1ps
module xmem_async_seq_bench;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_be = 2'b11;
    logic          rsp_done;
    logic [15:0]   rsp_rdata;
    logic [19:0]   cfg_rd_tim = '0;
    logic [19:0]   cfg_wr_tim = '0;
    logic [3:0]    cfg_lane_lead = '0;
    logic [1:0]    cfg_kind = 2'd0;
    logic          cfg_mux = 1'b0;
    logic          cfg_wide = 1'b1;
    logic          cfg_wait_en = 1'b0;
    logic          cfg_wait_high = 1'b0;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
    logic [1:0]    mem_bl_n;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_dq_out;
    logic [15:0]   mem_dq_in;
    logic          mem_wait = 1'b1;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] mdl(input logic [AW-1:0] a);
        return (a[15:0] * 16'd421) ^ 16'h5A3C;
    endfunction

    // marker outside the read strobe exposes late capture
    assign mem_dq_in = mem_oe_n ? 16'hDEAD : mdl(mem_addr);

    xmem_async_seq #(.ADDR_W(AW)) u_xmem_async_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .cfg_rd_tim(cfg_rd_tim), .cfg_wr_tim(cfg_wr_tim),
        .cfg_lane_lead(cfg_lane_lead), .cfg_kind(cfg_kind), .cfg_mux(cfg_mux),
        .cfg_wide(cfg_wide), .cfg_wait_en(cfg_wait_en),
        .cfg_wait_high(cfg_wait_high), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n),
        .mem_bl_n(mem_bl_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
    );

    typedef struct {
        string         tag;
        bit            w;
        bit            mux;
        int            lead, ce, stb, adv, aon, turn;
        logic [15:0]   data;
        logic [15:0]   adq;
        logic [1:0]    bl;
        logic [AW-1:0] addr;
    } exp_t;

    exp_t q[$];
    int   n_push = 0;
    int   n_done = 0;
    int   wait_left = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp_v);
        end
    endtask

    // wait driver: active level for wait_left strobe cycles
    always @(negedge clk) begin
        if ((!mem_oe_n || !mem_we_n) && wait_left > 0) begin
            mem_wait = cfg_wait_high;
            wait_left--;
        end else begin
            mem_wait = ~cfg_wait_high;
        end
    end

    // monitor: measures pin phases, pops expected item when bus is idle again
    bit            started = 0, stb_seen = 0;
    int            m_lead = 0, m_ce = 0, m_stb = 0, m_adv = 0, m_aon = 0, m_turn = 0;
    logic [15:0]   m_wd = '0, m_adq = '0, m_rd = '0;
    logic [1:0]    m_bl = 2'b11;
    logic [AW-1:0] m_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_done) begin
                m_rd = rsp_rdata;
                n_done++;
            end
            if (!mem_ce_n) begin
                started = 1;
                m_ce++;
                m_bl = mem_bl_n;
                m_addr = mem_addr;
            end else if (!started && mem_bl_n != 2'b11) begin
                m_lead++;
            end else if (started && !req_ready) begin
                m_turn++;
            end
            if (!mem_oe_n) begin m_stb++; stb_seen = 1; end
            if (!mem_we_n) begin m_stb++; stb_seen = 1; m_wd = mem_dq_out; end
            if (!mem_adv_n) begin m_adv++; m_adq = mem_dq_out; end
            if (mem_dq_oe && !stb_seen) m_aon++;
            if (started && req_ready) begin
                if (q.size() == 0) begin
                    chk("R11", "unexpected transaction", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.tag, "lane lead (R2)", m_lead, e.lead);
                    chk(e.tag, "chip select cycles (R2,R4)", m_ce, e.ce);
                    chk(e.tag, "strobe cycles (R4,R6)", m_stb, e.stb);
                    chk(e.tag, "address valid cycles (R5)", m_adv, e.adv);
                    chk(e.tag, "address on data bus cycles (R5)", m_aon, e.aon);
                    chk(e.tag, "turnaround (R10)", m_turn, e.turn);
                    chk(e.tag, "byte lanes (R9)", int'(m_bl), int'(e.bl));
                    chk(e.tag, "address lines", int'(m_addr), int'(e.addr));
                    if (e.mux) chk(e.tag, "muxed address value (R5)", int'(m_adq), int'(e.adq));
                    if (e.w) chk(e.tag, "write data (R3)", int'(m_wd), int'(e.data));
                    else     chk(e.tag, "read data (R8)", int'(m_rd), int'(e.data));
                end
                started = 0; stb_seen = 0;
                m_lead = 0; m_ce = 0; m_stb = 0; m_adv = 0; m_aon = 0; m_turn = 0;
                m_wd = '0; m_adq = '0; m_rd = 16'hFFFF; m_bl = 2'b11;
            end
        end
    end

    function automatic logic [19:0] pack(input int as, input int ah, input int ds, input int dh, input int tu);
        return {tu[3:0], dh[3:0], ds[3:0], ah[3:0], as[3:0]};
    endfunction

    // driver: computes expected result, pushes it, then performs the handshake
    task automatic txn(input string tag, input bit w, input logic [AW-1:0] a,
                       input logic [15:0] d, input logic [1:0] be, input int nw, input bit spam);
        exp_t        e;
        logic [19:0] t;
        logic [1:0]  lm;
        int          ds;
        t      = w ? cfg_wr_tim : cfg_rd_tim;
        lm     = cfg_wide ? 2'b11 : 2'b01;
        e.tag  = tag;
        e.w    = w;
        e.mux  = cfg_mux && (cfg_kind == 2'd1 || cfg_kind == 2'd2);
        ds     = (t[11:8] == 0) ? 1 : int'(t[11:8]);
        if (cfg_wait_en) ds += nw;
        e.lead = int'(cfg_lane_lead);
        e.stb  = ds;
        e.ce   = int'(t[3:0]) + (e.mux ? int'(t[7:4]) : 0) + ds + int'(t[15:12]);
        e.adv  = e.mux ? int'(t[3:0]) : 0;
        e.aon  = e.mux ? int'(t[3:0]) + int'(t[7:4]) : 0;
        e.turn = int'(t[19:16]);
        e.bl   = ~(be & lm);
        e.addr = a;
        e.adq  = a[15:0];
        e.data = (w ? d : mdl(a)) & (cfg_wide ? 16'hFFFF : 16'h00FF);
        q.push_back(e);
        n_push++;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        wait_left = nw;
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 0;
        if (spam) begin
            for (int k = 0; k < 3; k++) begin
                req_valid = 1; req_write = !w; req_addr = a ^ 20'h0F0F0;
                @(negedge clk);
            end
            req_valid = 0;
        end
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired, all requirements incomplete");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ce_n", mem_ce_n, 1);
        chk("R1", "oe_n", mem_oe_n, 1);
        chk("R1", "we_n", mem_we_n, 1);
        chk("R1", "adv_n", mem_adv_n, 1);
        chk("R1", "bl_n", int'(mem_bl_n), 3);
        chk("R1", "dq_oe", mem_dq_oe, 0);
        chk("R1", "ready", req_ready, 1);
        chk("R1", "done", rsp_done, 0);
        rst = 0;
        @(negedge clk);

        // R2 plain read, R3 write with its own set
        cfg_rd_tim = pack(2, 1, 3, 1, 2);
        cfg_wr_tim = pack(1, 3, 4, 2, 0);
        cfg_lane_lead = 4'd1;
        txn("R2", 0, 20'h01234, 16'h0, 2'b11, 0, 0);
        cfg_lane_lead = 4'd2;
        txn("R3", 1, 20'h05678, 16'hBEEF, 2'b01, 0, 0);

        // R4 zero phases skipped, data setup minimum one
        cfg_rd_tim = pack(0, 0, 0, 0, 0);
        cfg_lane_lead = 4'd0;
        txn("R4", 0, 20'h00ABC, 16'h0, 2'b11, 0, 0);

        // R5 multiplexed on PSRAM read and NOR write, ignored on SRAM
        cfg_rd_tim = pack(2, 2, 2, 1, 1);
        cfg_wr_tim = pack(3, 1, 2, 1, 1);
        cfg_mux = 1; cfg_kind = 2'd1;
        txn("R5", 0, 20'h4C0DE, 16'h0, 2'b11, 0, 0);
        cfg_kind = 2'd2;
        txn("R5", 1, 20'h3A55A, 16'h1357, 2'b11, 0, 0);
        cfg_kind = 2'd0;
        txn("R5", 0, 20'h12121, 16'h0, 2'b11, 0, 0);
        cfg_mux = 0;

        // R6 R7 wait enabled, both polarities; then disabled and ignored
        cfg_wait_en = 1; cfg_wait_high = 0;
        @(negedge clk);
        txn("R7", 0, 20'h00777, 16'h0, 2'b11, 3, 0);
        cfg_wait_high = 1;
        @(negedge clk);
        txn("R7", 1, 20'h00888, 16'hC0DE, 2'b11, 2, 0);
        cfg_wait_en = 0;
        txn("R6", 0, 20'h00999, 16'h0, 2'b11, 4, 0);
        cfg_wait_high = 0;
        @(negedge clk);

        // R9 narrow bus
        cfg_wide = 0;
        txn("R9", 0, 20'h0ACE1, 16'h0, 2'b11, 0, 0);
        txn("R9", 1, 20'h0ACE2, 16'hA5F0, 2'b11, 0, 0);
        cfg_wide = 1;

        // R8 capture with long strobe and data hold, R10 long turnaround
        cfg_rd_tim = pack(1, 0, 5, 3, 6);
        cfg_lane_lead = 4'd3;
        txn("R8", 0, 20'h7FFFF, 16'h0, 2'b10, 0, 0);
        txn("R10", 0, 20'h00010, 16'h0, 2'b11, 0, 0);

        // R11 requests while busy are not taken
        txn("R11", 1, 20'h00F00, 16'h6789, 2'b11, 0, 1);
        repeat (10) @(negedge clk);
        chk("R11", "completed transactions", n_done, n_push);
        chk("R11", "pending expected items", q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule